// File: doc/BRIEF.md
# Framed Link Transmitter

This block is the transmit half of a narrow point-to-point display link. On each parallel-clock strobe it captures a 22-bit word and sends it one bit at a time as a framed serial word. Each frame is built in this order: a forced-zero lead slot, then the data bits least significant first, then two trailer slots. A fast system clock runs the block, and a slot-tick enable advances the serial bit. The surrounding logic supplies exactly one tick per frame slot, so there are 25 ticks per parallel period, and the tick that arrives with the strobe opens slot 0.

The block also runs the link's power sequencing. While the active-low power input is low, the line is left undriven, and this idle line is how the far end learns to power down. When power returns, a lock period is modelled as a fixed count of system-clock cycles. The line is then driven from the next strobe onward, and a synchronization run of strobes must pass before the ready flag announces that data is valid. If the receiver pulls the line high to report a lost word boundary, the block releases the line, waits out a timed back-off, and repeats the whole lock and synchronization sequence.

Top module: `framed_link_tx`

## Requirements
- R1: On a cycle where `par_strobe` is high, the word on `par_data` is captured. One cycle later, slot 0 of the new frame (value 0) is on `ser_out`, and the tick given with the strobe counts as slot 0.
- R2: After slot 0, each slot tick advances the frame one slot, one cycle after the tick. Slots 1 to 22 carry data bits 0 to 21 in ascending order.
- R3: Slots 23 and 24 both carry the inverse of data bit 21. No level change occurs between them, and further ticks without a strobe hold that level.
- R4: On cycles without a slot tick or strobe, `ser_out` keeps its value.
- R5: One cycle after `pdn_n` is sampled low, `ser_oe` and `link_ready` are 0. They stay 0 while `pdn_n` is low, and `ser_out` is 0 whenever `ser_oe` is 0.
- R6: After `pdn_n` is sampled high, or after a back-off ends, the line stays undriven for LOCK_CYC system cycles. `ser_oe` then rises one cycle after the first strobe sampled after the lock period.
- R7: `link_ready` rises one cycle after the SYNC_WORDS-th strobe counted from, and including, the strobe that raised `ser_oe`. It is never high while `ser_oe` is low.
- R8: If `line_pulled_up` is sampled high while `ser_oe` is high, `ser_oe` and `link_ready` are 0 in the next cycle. The block stays idle for BACKOFF_CYC cycles and then re-enters the lock period of R6.
- R9: `line_pulled_up` has no effect while the line is not driven (powered down, in lock, or in back-off). It neither starts a back-off nor delays the lock timing.
- R10: When a pull-up arrives in the same cycle as the strobe that would complete synchronization, the back-off wins and `link_ready` stays 0.
- R11: During reset, `ser_out`, `ser_oe` and `link_ready` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| par_data | input | DATA_W (22) | Parallel word to send |
| par_strobe | input | 1 | One-cycle pulse marking a parallel-clock rising edge |
| slot_tick | input | 1 | Slot advance enable, 25 per parallel period |
| pdn_n | input | 1 | Power input, low requests power-down |
| line_pulled_up | input | 1 | Receiver has pulled the line high (boundary fault) |
| ser_out | output | 1 | Serial frame bit |
| ser_oe | output | 1 | Line driven when high, idle when low |
| link_ready | output | 1 | Synchronization complete, data is valid |

## Verification
Two pairs of events can fall into one cycle. In normal operation, the slot tick always lands together with the strobe, so the scoreboard's 25-items-per-frame alignment judges whether a frame restart overrides a shift. The harder pair is a receiver pull-up arriving on the very strobe that would finish synchronization. The bench schedules the pull-up onto that strobe by counting driven strobes, and it expects the line to drop with ready still low. After that, it expects a fresh lock window measured from the end of the back-off.

// File: rtl/flt_pkg.sv
package flt_pkg;

    typedef enum logic [2:0] {
        LNK_OFF     = 3'd0,
        LNK_LOCK    = 3'd1,
        LNK_SYNC    = 3'd2,
        LNK_RUN     = 3'd3,
        LNK_HOLDOFF = 3'd4
    } lnk_state_e;

    localparam int unsigned LEAD_W  = 1;
    localparam int unsigned TRAIL_W = 2;

endpackage

// File: rtl/flt_frame_shifter.sv
module flt_frame_shifter
    import flt_pkg::*;
#(
    parameter int unsigned DATA_W = 22
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic              tick,
    input  logic [DATA_W-1:0] word,
    output logic              line_bit
);

    localparam int unsigned FRAME_W    = LEAD_W + DATA_W + TRAIL_W;
    localparam int unsigned SLOT_W     = $clog2(FRAME_W);
    localparam int unsigned LAST_SLOT  = FRAME_W - 1;
    localparam int unsigned TRAIL_BASE = LEAD_W + DATA_W;

    typedef struct packed {
        logic [FRAME_W-1:0] frm;
        logic [SLOT_W-1:0]  slot;
    } shf_s;

    shf_s q, d;
    logic [FRAME_W-1:0] fresh;

    // Frame image: lead slots low, data LSB first, trailer = inverse of MSB
    for (genvar gl = 0; gl < LEAD_W; gl++) begin : g_lead
        assign fresh[gl] = 1'b0;
    end
    for (genvar gd = 0; gd < DATA_W; gd++) begin : g_data
        assign fresh[LEAD_W + gd] = word[gd];
    end
    for (genvar gt = 0; gt < TRAIL_W; gt++) begin : g_trail
        assign fresh[TRAIL_BASE + gt] = ~word[DATA_W-1];
    end

    always_comb begin
        d = q;
        if (load) begin
            d.frm  = fresh;
            d.slot = '0;
        end else if (tick) begin
            d.frm = {q.frm[FRAME_W-1], q.frm[FRAME_W-1:1]};
            if (q.slot != SLOT_W'(LAST_SLOT)) begin
                d.slot = q.slot + SLOT_W'(1);
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '0;
        end else begin
            q <= d;
        end
    end

    assign line_bit = q.frm[0];

    AST_LEAD_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        load |=> !line_bit); // R1

    AST_TRAIL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (q.slot == SLOT_W'(TRAIL_BASE) && tick && !load) |=> $stable(line_bit)); // R3

    AST_SLOT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (!tick && !load) |=> $stable(line_bit)); // R4

endmodule

// File: rtl/flt_link_ctrl.sv
module flt_link_ctrl
    import flt_pkg::*;
#(
    parameter int unsigned LOCK_CYC    = 64,
    parameter int unsigned SYNC_WORDS  = 4096,
    parameter int unsigned BACKOFF_CYC = 125
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pdn_n,
    input  logic strobe,
    input  logic pull,
    output logic oe,
    output logic ready
);

    localparam int unsigned MAX_A   = (LOCK_CYC > SYNC_WORDS) ? LOCK_CYC : SYNC_WORDS;
    localparam int unsigned TMR_MAX = (MAX_A > BACKOFF_CYC) ? MAX_A : BACKOFF_CYC;
    localparam int unsigned TMR_W   = $clog2(TMR_MAX + 1);

    typedef struct packed {
        lnk_state_e       st;
        logic [TMR_W-1:0] cnt;
        logic             oe;
        logic             rdy;
    } ctl_s;

    ctl_s q, d;

    always_comb begin
        d = q;
        if (!pdn_n) begin
            d.st  = LNK_OFF;
            d.cnt = '0;
            d.oe  = 1'b0;
            d.rdy = 1'b0;
        end else begin
            unique case (q.st)
                LNK_OFF: begin
                    d.st  = LNK_LOCK;
                    d.cnt = '0;
                end
                LNK_LOCK: begin
                    if (q.cnt == TMR_W'(LOCK_CYC - 1)) begin
                        d.st  = LNK_SYNC;
                        d.cnt = '0;
                    end else begin
                        d.cnt = q.cnt + TMR_W'(1);
                    end
                end
                LNK_SYNC: begin
                    if (pull && q.oe) begin
                        d.st  = LNK_HOLDOFF;
                        d.cnt = '0;
                        d.oe  = 1'b0;
                    end else if (strobe) begin
                        d.oe = 1'b1;
                        if (q.cnt == TMR_W'(SYNC_WORDS - 1)) begin
                            d.st  = LNK_RUN;
                            d.cnt = '0;
                            d.rdy = 1'b1;
                        end else begin
                            d.cnt = q.cnt + TMR_W'(1);
                        end
                    end
                end
                LNK_RUN: begin
                    if (pull) begin
                        d.st  = LNK_HOLDOFF;
                        d.cnt = '0;
                        d.oe  = 1'b0;
                        d.rdy = 1'b0;
                    end
                end
                LNK_HOLDOFF: begin
                    if (q.cnt == TMR_W'(BACKOFF_CYC - 1)) begin
                        d.st  = LNK_LOCK;
                        d.cnt = '0;
                    end else begin
                        d.cnt = q.cnt + TMR_W'(1);
                    end
                end
                default: begin
                    d.st  = LNK_OFF;
                    d.cnt = '0;
                    d.oe  = 1'b0;
                    d.rdy = 1'b0;
                end
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '{st: LNK_OFF, cnt: '0, oe: 1'b0, rdy: 1'b0};
        end else begin
            q <= d;
        end
    end

    assign oe    = q.oe;
    assign ready = q.rdy;

    AST_PDN_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !pdn_n |=> (!oe && !ready)); // R5

    AST_OE_ON_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(oe) |-> $past(strobe)); // R6

    AST_READY_NEEDS_OE: assert property (@(posedge clk) disable iff (!rst_n)
        ready |-> oe); // R7

    AST_PULLUP_BACKOFF: assert property (@(posedge clk) disable iff (!rst_n)
        (pull && oe && pdn_n) |=> (!oe && !ready)); // R8

    AST_PULL_BEATS_SYNC: assert property (@(posedge clk) disable iff (!rst_n)
        (pull && strobe && oe && !ready && pdn_n) |=> !ready); // R10

endmodule

// File: rtl/framed_link_tx.sv
module framed_link_tx
    import flt_pkg::*;
#(
    parameter int unsigned DATA_W      = 22,
    parameter int unsigned LOCK_CYC    = 64,
    parameter int unsigned SYNC_WORDS  = 4096,
    parameter int unsigned BACKOFF_CYC = 125
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [DATA_W-1:0] par_data,
    input  logic              par_strobe,
    input  logic              slot_tick,
    input  logic              pdn_n,
    input  logic              line_pulled_up,
    output logic              ser_out,
    output logic              ser_oe,
    output logic              link_ready
);

    logic frame_bit;

    flt_frame_shifter #(
        .DATA_W (DATA_W)
    ) u_shift (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (par_strobe),
        .tick     (slot_tick),
        .word     (par_data),
        .line_bit (frame_bit)
    );

    flt_link_ctrl #(
        .LOCK_CYC    (LOCK_CYC),
        .SYNC_WORDS  (SYNC_WORDS),
        .BACKOFF_CYC (BACKOFF_CYC)
    ) u_ctrl (
        .clk    (clk),
        .rst_n  (rst_n),
        .pdn_n  (pdn_n),
        .strobe (par_strobe),
        .pull   (line_pulled_up),
        .oe     (ser_oe),
        .ready  (link_ready)
    );

    assign ser_out = ser_oe & frame_bit;

    AST_IDLE_LINE_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        !pdn_n |=> !ser_out); // R5

endmodule

// File: tb/framed_link_tx_tb.sv
module framed_link_tx_tb;

    localparam int DW  = 22;
    localparam int LCK = 40;
    localparam int SW  = 8;
    localparam int BO  = 125;
    localparam int FS  = 25;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [DW-1:0] par_data = '0;
    logic          par_strobe = 1'b0;
    logic          slot_tick = 1'b0;
    logic          pdn_n = 1'b0;
    logic          line_pulled_up = 1'b0;
    logic          ser_out, ser_oe, link_ready;

    always #4 clk = ~clk;

    framed_link_tx #(
        .DATA_W(DW), .LOCK_CYC(LCK), .SYNC_WORDS(SW), .BACKOFF_CYC(BO)
    ) u_dut (
        .clk(clk), .rst_n(rst_n), .par_data(par_data), .par_strobe(par_strobe),
        .slot_tick(slot_tick), .pdn_n(pdn_n), .line_pulled_up(line_pulled_up),
        .ser_out(ser_out), .ser_oe(ser_oe), .link_ready(link_ready)
    );

    int n_chk = 0;
    int n_bad = 0;
    int cyc = 0;
    logic [5:0] expq[$];

    int per_k = 1;
    int mode = 0;
    bit pull_now = 0;
    bit pull_at_strobe = 0;
    logic [DW-1:0] lfsr = 22'h15A3C7;

    always @(posedge clk) cyc <= cyc + 1;

    task automatic check(input bit ok, input string req, input int act, input int exp_v);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d (cycle %0d)", req, act, exp_v, cyc);
        end
    endtask

    task automatic step();
        @(posedge clk);
        #1;
    endtask

    // Driver: one frame per parallel period, expected slots pushed to the scoreboard
    task automatic drive_forever();
        forever begin
            logic [DW-1:0] w;
            int kk;
            kk = per_k;
            case (mode)
                0: begin
                    lfsr = {lfsr[DW-2:0], lfsr[DW-1] ^ lfsr[DW-2]};
                    w = lfsr;
                end
                1: w = '0;
                2: w = '1;
                default: w = 22'h2AAAAA;
            endcase
            expq.push_back({5'd0, 1'b0});
            for (int i = 0; i < DW; i++) expq.push_back({5'(i + 1), w[i]});
            expq.push_back({5'd23, ~w[DW-1]});
            expq.push_back({5'd24, ~w[DW-1]});
            for (int s = 0; s < FS; s++) begin
                for (int k = 0; k < kk; k++) begin
                    par_strobe = (s == 0 && k == 0);
                    slot_tick  = (k == 0);
                    par_data   = w;
                    line_pulled_up = 1'b0;
                    if (s == 0 && k == 0 && pull_at_strobe) begin
                        line_pulled_up = 1'b1;
                        pull_at_strobe = 0;
                    end else if (pull_now) begin
                        line_pulled_up = 1'b1;
                        pull_now = 0;
                    end
                    step();
                end
            end
        end
    endtask

    // Monitor state
    logic oe_p = 0, ser_p = 0, strobe_p = 0, tick_p = 0, pdn_p = 0;
    bit quiet_due = 0, r9_due = 0, r10_due = 0;
    string qtag = "R5";
    int ls = -100000;
    int seen = 0;

    always @(negedge clk) begin
        if (rst_n) begin
            if (quiet_due) check(!ser_oe && !link_ready, qtag, {ser_oe, link_ready}, 0);
            if (quiet_due && qtag == "R5") check(ser_out == 1'b0, "R5", ser_out, 0);
            if (r9_due) check(!ser_oe && !link_ready, "R9", {ser_oe, link_ready}, 0);
            if (r10_due) check(!link_ready && !ser_oe, "R10", {ser_oe, link_ready}, 0);

            // Scoreboard: one expected slot per tick
            if (tick_p && expq.size() > 0) begin
                logic [5:0] it;
                it = expq.pop_front();
                if (ser_oe) begin
                    if (it[5:1] == 5'd0)
                        check(ser_out == it[0], "R1", ser_out, it[0]);
                    else if (it[5:1] <= 5'd22)
                        check(ser_out == it[0], "R2", ser_out, it[0]);
                    else
                        check(ser_out == it[0], "R3", ser_out, it[0]);
                end
            end else if (!tick_p && !strobe_p && ser_oe && oe_p) begin
                check(ser_out == ser_p, "R4", ser_out, ser_p);
            end

            // Lock window: line first driven on first strobe after LOCK_CYC
            if (ser_oe && !oe_p) begin
                check(strobe_p == 1'b1, "R6", strobe_p, 1);
                check((cyc - ls) >= LCK + 1 && (cyc - ls) <= LCK + FS * per_k,
                      "R6", cyc - ls, LCK + 1);
            end

            // Synchronization run
            if (strobe_p && ser_oe) begin
                seen++;
                check(link_ready == (seen >= SW), "R7", link_ready, seen >= SW);
            end
            if (!ser_oe) seen = 0;
            if (link_ready && !ser_oe) check(0, "R7", link_ready, 0);

            // Schedule next-cycle expectations
            quiet_due = !pdn_n || (line_pulled_up && ser_oe);
            qtag = !pdn_n ? "R5" : "R8";
            r9_due = pdn_n && line_pulled_up && !ser_oe && !par_strobe;
            r10_due = pdn_n && line_pulled_up && par_strobe && ser_oe && !link_ready;
            if (pdn_n && line_pulled_up && ser_oe) ls = cyc + 1 + BO;
            if (pdn_n && !pdn_p) ls = cyc + 1;

            oe_p = ser_oe;
            ser_p = ser_out;
            strobe_p = par_strobe;
            tick_p = slot_tick;
            pdn_p = pdn_n;
        end
    end

    task automatic wait_ready();
        while (!link_ready) step();
    endtask

    task automatic finish_run();
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    endtask

    initial begin
        repeat (60000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL R7 watchdog expired, actual=hung expected=done");
        finish_run();
    end

    initial begin
        repeat (5) step();
        // R11: reset state
        check(ser_out == 1'b0, "R11", ser_out, 0);
        check(ser_oe == 1'b0, "R11", ser_oe, 0);
        check(link_ready == 1'b0, "R11", link_ready, 0);
        rst_n = 1'b1;
        repeat (3) step();
        fork
            drive_forever();
        join_none

        // Powered down: line idle; a pull-up here must do nothing (R9)
        repeat (60) step();
        pull_now = 1;
        repeat (30) step();

        // Power up: lock, sync, ready (R6, R7)
        pdn_n = 1'b1;
        wait_ready();

        // Several data patterns (R1, R2, R3)
        repeat (5 * FS) step();
        mode = 1; repeat (3 * FS) step();
        mode = 2; repeat (3 * FS) step();
        mode = 3; repeat (3 * FS) step();
        mode = 0;

        // Slow ticks: output holds between ticks (R4)
        while (!par_strobe) step();
        per_k = 2;
        repeat (6 * FS) step();
        per_k = 1;
        repeat (3 * FS) step();

        // Remote fault while running (R8), then a pull-up during lock (R9)
        pull_now = 1;
        repeat (BO + 10) step();
        pull_now = 1;
        while (!ser_oe) step();

        // Pull-up on the strobe that would finish sync (R10)
        while (seen != SW - 1) step();
        pull_at_strobe = 1;
        repeat (2 * FS) step();
        wait_ready();
        repeat (3 * FS) step();

        // Power down mid-frame (R5)
        repeat (7) step();
        pdn_n = 1'b0;
        repeat (40) step();
        finish_run();
    end

endmodule